// File: doc/BRIEF.md
# Complementary Channel Control Commutation

This block keeps the control settings of one timer channel that drives a true and a complementary output. There are three settings: an enable for the true output, an enable for the complementary output, and a 3-bit output-compare mode. Software writes the settings through a simple write port. With staging switched off, a write reaches the outputs at once. With staging switched on, a write only fills a shadow copy. The active copy takes that value on a commutation event, so that several channels can switch configuration at the same instant.

A commutation event is always raised by a software strobe. When the source-select input is 1, a rising edge on the external trigger input also raises one. Each transfer sets a sticky done flag, and software clears it. A build parameter states whether the channel has a complementary output. Without one, staging is not available, and the complementary enable always reads 0.

Top module: `cc_commute_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with idle inputs, all three active settings and the done flag read 0.
- R2: When staging is off (`stage_en`=0), a write (`wr_en`=1) appears on the active outputs at the first rising clock edge after it is presented.
- R3: When staging is on, a write changes no active output until a commutation event occurs.
- R4: When staging is on, `com_sw`=1 copies the shadow settings to the active outputs at that clock edge.
- R5: When `trg_sel`=0, a rising edge on `trg_in` moves nothing and leaves the done flag low.
- R6: When `trg_sel`=1 and staging is on, a rise of `trg_in` is a clock sample of 1 that follows a sample of 0. That rise transfers at the edge where the 1 is sampled.
- R7: If `trg_in` is held high for many cycles, it causes at most one transfer.
- R8: If a write and a commutation event fall in the same cycle, the value being written goes straight to the active outputs.
- R9: `com_done` goes to 1 at the edge of a transfer and stays at 1 until `done_clr`=1 is sampled. If a transfer and a clear fall in the same cycle, the flag is set.
- R10: When `HAS_COMP`=0, writes always act at once, whatever `stage_en` holds. In that case `act_oen` stays 0 and `com_done` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control settings |
| wr_oe | input | 1 | Written true-output enable |
| wr_oen | input | 1 | Written complementary-output enable |
| wr_mode | input | 3 | Written output-compare mode |
| stage_en | input | 1 | 1: writes go to the shadow copy and wait for commutation |
| trg_sel | input | 1 | 1: a rising trigger edge also commutates |
| com_sw | input | 1 | Software commutation strobe |
| trg_in | input | 1 | Trigger input |
| done_clr | input | 1 | Clears the commutation-done flag |
| act_oe | output | 1 | Active true-output enable |
| act_oen | output | 1 | Active complementary-output enable |
| act_mode | output | 3 | Active output-compare mode |
| com_done | output | 1 | Sticky commutation-done flag |

## Verification
The bench targets the following corner cases:
- **Write and commutation in the same cycle.** A design that forwarded only the old shadow would lose the write for one full commutation.
- **Trigger held high.** A level detector instead of an edge detector would transfer on every cycle.
- **Trigger edge with `trg_sel`=0.** A design that ignored the select would commutate on its own.
- **Flag set and clear in the same cycle.** A design where the clear wins would hide a transfer from software.
- **Channel without a complementary output.** A second instance, built without it, must ignore staging entirely. A design that staged writes anyway would freeze its outputs.

// File: rtl/cc_commute_pkg.sv
package cc_commute_pkg;
  localparam int unsigned MODE_W = 3;

  typedef struct packed {
    logic              oe;
    logic              oen;
    logic [MODE_W-1:0] mode;
  } ch_ctl_t;

  localparam int unsigned CTL_W = $bits(ch_ctl_t);
endpackage

// File: rtl/cc_rst_sync.sv
module cc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/cc_trig_edge.sv
module cc_trig_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic trg_in,
  output logic rise
);
  logic trg_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) trg_q <= 1'b0;
    else         trg_q <= trg_in;
  end

  assign rise = trg_in & ~trg_q;

  // R7: a held level cannot yield two consecutive rises
  a_r7_single_rise: assert property (@(posedge clk) disable iff (!rst_ni)
    rise |=> !rise);
endmodule

// File: rtl/cc_ctl_bank.sv
module cc_ctl_bank
  import cc_commute_pkg::*;
#(
  parameter bit HAS_COMP = 1'b1
) (
  input  logic    clk,
  input  logic    rst_ni,
  input  logic    wr_en,
  input  ch_ctl_t wr_val,
  input  logic    stage_en,
  input  logic    com_evt,
  output ch_ctl_t act,
  output logic    xfer
);
  ch_ctl_t shd_q, shd_d;
  ch_ctl_t act_q, act_d;
  ch_ctl_t wr_eff;
  logic    stage_eff;

  generate
    if (HAS_COMP) begin : g_comp
      assign stage_eff = stage_en;
      assign wr_eff    = wr_val;
    end else begin : g_nocomp
      assign stage_eff = 1'b0;
      assign wr_eff    = '{oe: wr_val.oe, oen: 1'b0, mode: wr_val.mode};
    end
  endgenerate

  always_comb begin
    shd_d = wr_en ? wr_eff : shd_q;
    act_d = act_q;
    if (!stage_eff) begin
      if (wr_en) act_d = wr_eff;
    end else if (com_evt) begin
      act_d = shd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      shd_q <= shd_d;
      act_q <= act_d;
    end
  end

  assign act  = act_q;
  assign xfer = stage_eff & com_evt;

  // R2: direct mode write lands at the next edge
  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (!stage_eff && wr_en) |=> (act.oe == $past(wr_val.oe) && act.mode == $past(wr_val.mode)));
  // R3: staged settings hold without a commutation event
  a_r3_staged_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (stage_eff && !com_evt) |=> $stable(act));
  // R8: write coinciding with commutation is forwarded
  a_r8_write_forward: assert property (@(posedge clk) disable iff (!rst_ni)
    (stage_eff && com_evt && wr_en) |=> (act == $past(wr_val)));
endmodule

// File: rtl/cc_com_flag.sv
module cc_com_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb flag_d = set | (flag_q & ~clr);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R9: a transfer always shows in the flag, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_ni)
    set |=> flag);
  // R9: flag is sticky until cleared
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/cc_commute_ctrl.sv
module cc_commute_ctrl
  import cc_commute_pkg::*;
#(
  parameter bit HAS_COMP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_oe,
  input  logic              wr_oen,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic              stage_en,
  input  logic              trg_sel,
  input  logic              com_sw,
  input  logic              trg_in,
  input  logic              done_clr,
  output logic              act_oe,
  output logic              act_oen,
  output logic [MODE_W-1:0] act_mode,
  output logic              com_done
);
  logic    rst_ni;
  logic    trg_rise;
  logic    com_evt;
  logic    xfer;
  ch_ctl_t wr_val;
  ch_ctl_t act;

  cc_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_no(rst_ni));

  cc_trig_edge u_edge (.clk(clk), .rst_ni(rst_ni), .trg_in(trg_in), .rise(trg_rise));

  assign com_evt = com_sw | (trg_sel & trg_rise);
  assign wr_val  = '{oe: wr_oe, oen: wr_oen, mode: wr_mode};

  cc_ctl_bank #(.HAS_COMP(HAS_COMP)) u_bank (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .wr_val(wr_val),
    .stage_en(stage_en), .com_evt(com_evt), .act(act), .xfer(xfer)
  );

  cc_com_flag u_flag (.clk(clk), .rst_ni(rst_ni), .set(xfer), .clr(done_clr), .flag(com_done));

  assign act_oe   = act.oe;
  assign act_oen  = act.oen;
  assign act_mode = act.mode;

  // R5: with trigger source deselected, only the strobe can transfer
  a_r5_trig_ignored: assert property (@(posedge clk) disable iff (!rst_ni)
    (!trg_sel && !com_sw && !done_clr && !com_done) |=> !com_done);
  // R10: no complementary output means nothing is ever staged
  a_r10_no_comp: assert property (@(posedge clk) disable iff (!rst_ni)
    !HAS_COMP |-> (!act_oen && !com_done));
endmodule

// File: tb/cc_commute_ctrl_test.sv
`timescale 1ns/1ps
module cc_commute_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_oe = 0, wr_oen = 0, stage_en = 0, trg_sel = 0;
  logic com_sw = 0, trg_in = 0, done_clr = 0;
  logic [2:0] wr_mode = 0;
  logic act_oe, act_oen, com_done, nc_oe, nc_oen, nc_done;
  logic [2:0] act_mode, nc_mode;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  cc_commute_ctrl #(.HAS_COMP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_oe(wr_oe), .wr_oen(wr_oen),
    .wr_mode(wr_mode), .stage_en(stage_en), .trg_sel(trg_sel), .com_sw(com_sw),
    .trg_in(trg_in), .done_clr(done_clr), .act_oe(act_oe), .act_oen(act_oen),
    .act_mode(act_mode), .com_done(com_done));

  cc_commute_ctrl #(.HAS_COMP(1'b0)) uut_nc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_oe(wr_oe), .wr_oen(wr_oen),
    .wr_mode(wr_mode), .stage_en(stage_en), .trg_sel(trg_sel), .com_sw(com_sw),
    .trg_in(trg_in), .done_clr(done_clr), .act_oe(nc_oe), .act_oen(nc_oen),
    .act_mode(nc_mode), .com_done(nc_done));

  // reference model: integers, stepped on each edge
  int m_sh, m_act, m_flag, m_trg, n_act;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sh = 0; m_act = 0; m_flag = 0; m_trg = 0; n_act = 0;
    end else begin
      int w, evt;
      w   = {wr_oe, wr_oen, wr_mode};
      evt = com_sw || (trg_sel && trg_in && !m_trg);
      if (stage_en) begin
        if (wr_en) m_sh = w;
        if (evt) m_act = m_sh;
      end else if (wr_en) begin
        m_sh = w; m_act = w;
      end
      if (stage_en && evt) m_flag = 1;
      else if (done_clr)   m_flag = 0;
      if (wr_en) n_act = w & 'h17;
      m_trg = trg_in;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(phase, {act_oe, act_oen, act_mode, com_done}, {m_act[4:0], m_flag[0]});
    check("R10", {nc_oe, nc_oen, nc_mode, nc_done}, {n_act[4:0], 1'b0});
  end

  task automatic step(bit w, bit [4:0] v, bit sw, bit trg, bit clr);
    @(negedge clk);
    wr_en = w; {wr_oe, wr_oen, wr_mode} = v; com_sw = sw; trg_in = trg; done_clr = clr;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, trg_in, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {act_oe, act_oen, act_mode, com_done}, 0);
    rst_n = 1'b1;
    idle(4);
    check("R1", {act_oe, act_oen, act_mode, com_done}, 0);

    phase = "R2"; step(1, 5'b10_101, 0, 0, 0); idle(1);
    check("R2", {act_oe, act_oen, act_mode}, 5'b10_101);

    phase = "R3"; stage_en = 1; step(1, 5'b01_011, 0, 0, 0); idle(3);
    check("R3", {act_oe, act_oen, act_mode, com_done}, {5'b10_101, 1'b0});

    phase = "R4"; step(0, 0, 1, 0, 0); idle(1);
    check("R4", {act_oe, act_oen, act_mode}, 5'b01_011);
    check("R9", com_done, 1);
    phase = "R9"; idle(4);
    check("R9", com_done, 1);
    step(0, 0, 0, 0, 1); idle(1);
    check("R9", com_done, 0);

    phase = "R5"; trg_sel = 0; step(1, 5'b11_110, 0, 0, 0);
    step(0, 0, 0, 1, 0); idle(2); step(0, 0, 0, 0, 0); idle(1);
    check("R5", {act_oe, act_oen, act_mode, com_done}, {5'b01_011, 1'b0});

    phase = "R6"; trg_sel = 1; step(0, 0, 0, 1, 0); idle(1);
    check("R6", {act_oe, act_oen, act_mode, com_done}, {5'b11_110, 1'b1});
    step(0, 0, 0, 1, 1);

    phase = "R7"; step(1, 5'b00_010, 0, 1, 0); idle(6);
    check("R7", {act_oe, act_oen, act_mode, com_done}, {5'b11_110, 1'b0});
    step(0, 0, 0, 0, 0);

    phase = "R8"; step(1, 5'b10_111, 1, 0, 0); idle(1);
    check("R8", {act_oe, act_oen, act_mode}, 5'b10_111);

    phase = "R9"; step(0, 0, 1, 0, 1); idle(1);
    check("R9", com_done, 1);

    phase = "R10"; step(1, 5'b11_001, 0, 0, 1); idle(1);
    check("R10", {nc_oe, nc_oen, nc_mode, nc_done}, 5'b10_001 << 1);
    check("R3", {act_oe, act_oen, act_mode}, 5'b10_111);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule